// File: doc/BRIEF.md
# Strobe-Armed Serial Result Port

This block is the device-side read port of a 10-bit converter. The conversion sequencer hands it each finished result on a parallel bus with a one-cycle load pulse, and the port keeps that value in a holding register. A host reads the value over three wires. A single strobe input acts as both port enable and chip select. The host's serial clock shifts the bits out, and the port drives a data bit together with an output-enable for a tristate pad.

A rising edge on the strobe arms the port. It clears the bit counter and copies the holding register into the shift register, so a result that arrives during a frame cannot corrupt that frame. The most significant bit appears on the first rising serial clock edge after arming, and each later rising edge presents the next lower bit. On the falling edge that follows the last rising edge, the port releases the line. It then ignores the serial clock until the strobe rises again. The strobe and the serial clock are sampled in the system clock domain. The port does not depend on the converter core, so it can be read while the core is powered down.

Top module: `strobe_serial_port`

## Requirements
- R1: After reset, sdo_oe and sdo are 0, and the holding register is cleared, so a frame read before any load returns all zeros.
- R2: A rising strobe edge, seen at a system clock edge, sets sdo_oe to 1 one cycle later with sdo at 0. Serial clock activity without a rising strobe edge leaves sdo_oe at 0.
- R3: Each rising serial clock edge in an armed frame puts the next bit on sdo, one system clock later. The first edge gives bit WIDTH-1 (MSB first), and sdo does not change between these edges.
- R4: A frame carries exactly WIDTH bits. sdo_oe stays 1 through the falling serial clock edges after bits 1 to WIDTH-1, and drops to 0 one cycle after the falling edge that follows the WIDTH-th rising edge.
- R5: Once a frame has ended, further serial clock edges leave sdo_oe and sdo at 0 until the next rising strobe edge.
- R6: The frame shifts out the value the holding register had when the strobe rose. A result_load during the frame does not change the remaining bits, and the next frame returns the new value.
- R7: A frame armed before a new result is loaded returns the previously loaded result.
- R8: A rising strobe edge during a frame restarts it: the counter clears and the next rising serial clock edge presents bit WIDTH-1 again.
- R9: sdo is 0 whenever sdo_oe is 0.
- R10: The frame works the same with a free-running serial clock (toggling every system cycle) and with a gated, uneven one. A falling strobe edge or a held strobe level has no effect on a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples strobe and sclk |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Port enable; rising edge arms a frame |
| sclk | input | 1 | Host serial clock |
| result | input | WIDTH | Finished conversion result from the sequencer |
| result_load | input | 1 | Load pulse that latches result into the holding register |
| sdo | output | 1 | Serial data bit, 0 when not enabled |
| sdo_oe | output | 1 | Output-enable for the tristate data pad |

## Verification
The bench builds the port with WIDTH at its default of 10. Every full frame therefore covers all ten bit positions, the counter's terminal value and the line release on the tenth falling edge. Serial clock phases of one system cycle and of several cycles cover the free-running and gated cases. The data patterns include all ones, a single one in the LSB and mixed values, so a stuck or swapped bit position shows up.

// File: rtl/strobe_serial_port.sv
module strobe_serial_port #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             sclk,
  input  logic [WIDTH-1:0] result,
  input  logic             result_load,
  output logic             sdo,
  output logic             sdo_oe
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH);

  logic             strobe_q, sclk_q;
  logic [WIDTH-1:0] hold_r, shift_r;
  logic             sdo_r, armed;
  logic [CW-1:0]    cnt;

  wire strobe_rise = strobe & ~strobe_q;
  wire sclk_rise   = sclk & ~sclk_q;
  wire sclk_fall   = ~sclk & sclk_q;
  wire more_bits   = (cnt != LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      sclk_q   <= 1'b0;
    end else begin
      strobe_q <= strobe;
      sclk_q   <= sclk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           hold_r <= '0;
    else if (result_load) hold_r <= result;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_r <= '0;
      sdo_r   <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
    end else if (strobe_rise) begin
      shift_r <= hold_r;
      sdo_r   <= 1'b0;
      armed   <= 1'b1;
      cnt     <= '0;
    end else if (armed) begin
      if (sclk_rise && more_bits) begin
        sdo_r   <= shift_r[WIDTH-1];
        shift_r <= {shift_r[WIDTH-2:0], 1'b0};
        cnt     <= cnt + 1'b1;
      end else if (sclk_fall && !more_bits) begin
        armed <= 1'b0;
        sdo_r <= 1'b0;
      end
    end
  end

  assign sdo_oe = armed;
  assign sdo    = armed & sdo_r;
endmodule

// File: rtl/strobe_serial_port_chk.sv
module strobe_serial_port_chk #(
  parameter int WIDTH = 10
) (
  input logic clk,
  input logic rst_n,
  input logic strobe,
  input logic sclk,
  input logic sdo,
  input logic sdo_oe
);
  localparam int CW = $clog2(WIDTH + 1);

  logic          s_q, c_q, ev_q;
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q  <= 1'b0;
      c_q  <= 1'b0;
      ev_q <= 1'b0;
      seen <= '0;
    end else begin
      s_q  <= strobe;
      c_q  <= sclk;
      ev_q <= (sclk & ~c_q) | (strobe & ~s_q);
      if (strobe & ~s_q)                      seen <= '0;
      else if ((sclk & ~c_q) && seen != CW'(WIDTH)) seen <= seen + 1'b1;
    end
  end

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !s_q) |=> sdo_oe);

  assert_arm_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(strobe));

  assert_frame_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe) |-> seen == CW'(WIDTH));

  assert_hold_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !ev_q) |-> $stable(sdo));

  assert_stay_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_oe && !(strobe && !s_q)) |=> !sdo_oe);
endmodule

bind strobe_serial_port strobe_serial_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .sclk(sclk),
  .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/sim_strobe_serial_port.sv
`timescale 1ns/1ps
module sim_strobe_serial_port;
  localparam int WIDTH = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic sclk = 1'b0;
  logic [WIDTH-1:0] result = '0;
  logic result_load = 1'b0;
  logic sdo, sdo_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strobe_serial_port #(.WIDTH(WIDTH)) u0 (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sclk(sclk),
    .result(result), .result_load(result_load), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic load(input logic [WIDTH-1:0] v);
    @(negedge clk); result = v; result_load = 1'b1;
    @(negedge clk); result_load = 1'b0;
  endtask

  task automatic arm(input string req);
    @(negedge clk); strobe = 1'b1;
    @(negedge clk);
    check(req, sdo_oe, 1'b1, "oe after strobe rise");
    check("R2", sdo, 1'b0, "sdo before first sclk");
  endtask

  task automatic bit_cycle(input string req, input logic exp_bit, input logic last,
                           input int hi, input int lo);
    @(negedge clk); sclk = 1'b1;
    @(negedge clk);
    check(req, sdo, exp_bit, "bit value");
    repeat (hi - 1) @(negedge clk);
    check("R3", sdo, exp_bit, "bit held while sclk high");
    sclk = 1'b0;
    @(negedge clk);
    check("R4", sdo_oe, !last, "oe after falling edge");
    repeat (lo - 1) @(negedge clk);
  endtask

  task automatic frame(input string req, input logic [WIDTH-1:0] exp, input int hi, input int lo);
    arm(req);
    strobe = 1'b0;
    for (int i = 0; i < WIDTH; i++)
      bit_cycle(req, exp[WIDTH-1-i], i == WIDTH-1, hi, lo);
    check("R9", sdo, 1'b0, "sdo after frame");
  endtask

  task automatic t_reset;
    check("R1", sdo_oe, 1'b0, "oe at reset");
    check("R1", sdo, 1'b0, "sdo at reset");
    frame("R1", '0, 1, 1);
  endtask

  task automatic t_no_strobe;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
      check("R2", sdo_oe, 1'b0, "oe without strobe");
      check("R9", sdo, 1'b0, "sdo without strobe");
    end
  endtask

  task automatic t_continuous;
    load(10'h2B5);
    frame("R10", 10'h2B5, 1, 1);
  endtask

  task automatic t_extra_clocks;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); sclk = 1'b1;
      @(negedge clk);
      check("R5", sdo_oe, 1'b0, "oe on extra sclk");
      check("R5", sdo, 1'b0, "sdo on extra sclk");
      sclk = 1'b0;
    end
  endtask

  task automatic t_gated;
    load(10'h3FF);
    frame("R10", 10'h3FF, 3, 5);
    load(10'h001);
    frame("R3", 10'h001, 2, 4);
  endtask

  task automatic t_midframe_load;
    load(10'h155);
    arm("R6");
    @(negedge clk); strobe = 1'b0;
    for (int i = 0; i < 4; i++) bit_cycle("R6", 10'h155 >> (WIDTH-1-i), 1'b0, 1, 2);
    load(10'h0CA);
    for (int i = 4; i < WIDTH; i++) bit_cycle("R7", 1'((10'h155 >> (WIDTH-1-i))), i == WIDTH-1, 1, 2);
    frame("R6", 10'h0CA, 2, 2);
  endtask

  task automatic t_restart;
    load(10'h2C3);
    arm("R8");
    for (int i = 0; i < 3; i++) bit_cycle("R10", 1'((10'h2C3 >> (WIDTH-1-i))), 1'b0, 1, 1);
    strobe = 1'b0;
    load(10'h13C);
    frame("R8", 10'h13C, 1, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_strobe();
    t_continuous();
    t_extra_clocks();
    t_gated();
    t_midframe_load();
    t_restart();
    t_extra_clocks();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule